// File: doc/BRIEF.md
# Synchronous Serial Receiver with Sync Hunt

This block turns a serial bit stream into characters. A bit-clock enable marks each bit. Data bits arrive least significant first, and everything runs in a single system clock domain. Software sets the character length (5 to 8 data bits), turns parity on or off, chooses its sense, and loads a sync pattern.

There are three framing modes:
- **Internal synchronous:** with the search control raised, the receiver slides a bit window over the stream. Character framing starts only after one or two back-to-back frames have matched the sync pattern.
- **External synchronous:** framing starts at once when search is raised.
- **Start/stop:** each character waits for a low start bit, and a stop bit is checked after the data.

Each framed character goes into a holding buffer together with parity, framing and overrun flags, and a done flag is raised. A request line is the done flag gated by the interrupt enable. Reading the buffer through the read strobe clears the done flag and the error flags. When stripping is on, an error-free copy of the sync character is dropped without a trace. This keeps idle fill characters away from software.

Top module: `ssrx_top`

## Requirements
- R1: After reset `rx_buf` reads 16'h00FF: data field all ones, every flag clear. `done`, `irq` and `in_sync` are low.
- R2: In internal synchronous mode (`mode`=00) with `need_two`=1, `in_sync` rises only after two back-to-back frames that equal the sync pattern. The pattern is the data bits plus a parity bit when parity is on. One sync frame followed by a different frame does not set `in_sync`. Frames received during the hunt are not delivered.
- R3: In internal synchronous mode with `need_two`=0, a single matching frame sets `in_sync`.
- R4: In external synchronous mode (`mode`=01) and start/stop mode (`mode`=1x), `in_sync` equals `search_en`.
- R5: `word_len` 00/01/10/11 selects 5/6/7/8 data bits. Bits are received least significant first and placed right-justified in `rx_buf[7:0]`. Unused upper data bits read 0.
- R6: With `par_en`=1 and fewer than 8 data bits, the received parity bit appears in `rx_buf` at the bit just above the data (bit n for n data bits). With 8 data bits it is not shown.
- R7: `rx_buf[14]` is the parity error flag. With `par_even`=1 the data plus parity must hold an even number of ones; with `par_even`=0, an odd number. The flag is always 0 when `par_en`=0.
- R8: `rx_buf[13]` is the framing error flag. It is set only in start/stop mode, when the bit after the data (and parity) is 0.
- R9: `rx_buf[12]` is the overrun flag. It is set when a character is stored while `done` is still high, and the new character replaces the old data.
- R10: `rx_buf[15]` is the OR of bits 14, 13 and 12. `rx_buf[11:8]` read 0.
- R11: With `strip_en`=1, a character is dropped when its data bits equal the sync character and it has neither a parity nor a framing error. `done` and `rx_buf` stay unchanged. A sync character with an error is stored normally.
- R12: A `rd_strobe` pulse clears `done` and the three error flags and keeps the data field. When a character is stored in the same cycle, the store wins and its overrun flag is 0.
- R13: `irq` is high exactly when `done` and `rx_ie` are both high.
- R14: While `search_en` is low, no character is delivered and `in_sync` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe marking a valid serial bit |
| ser_in | input | 1 | Serial data input |
| mode | input | 2 | 00 internal sync, 01 external sync, 1x start/stop |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| need_two | input | 1 | 1 requires two matching sync frames, 0 requires one |
| sync_char | input | 8 | Sync pattern, right-justified |
| search_en | input | 1 | Start hunt or framing; low halts the receiver |
| strip_en | input | 1 | Drop error-free sync characters |
| rx_ie | input | 1 | Receiver interrupt enable |
| rd_strobe | input | 1 | Buffer read pulse |
| rx_buf | output | 16 | {err, parity err, framing err, overrun, 4'b0, data} |
| done | output | 1 | Character waiting |
| irq | output | 1 | Interrupt request |
| in_sync | output | 1 | Synchronization achieved |

## Verification
The hunt is driven with idle ones, with a single sync frame followed by a foreign frame, and with a proper sync pair. This separates one-match from two-match acquisition and exposes false early matches.

Random characters are then sent at every length, with and without parity and in both senses, with parity errors injected now and then. This separates bit placement, parity position and the parity check.

Directed sequences cover the rest:
- unread back-to-back characters (overrun);
- sync characters with and without errors while stripping is on;
- start/stop frames with good and bad stop bits;
- traffic while search is off.

// File: rtl/ssrx_pkg.sv
// Shared constants, frame state type and helper functions of the serial receiver.
// Assumes a maximum of 8 data bits and a 2-bit length code of (bits - 5).
package ssrx_pkg;
    localparam int DATA_W = 8;
    localparam int WIN_W  = DATA_W + 1;
    localparam int LEN_W  = 2;
    localparam int CNT_W  = $clog2(WIN_W + 1);
    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HUNT, ST_CONFIRM, ST_FRAME, ST_START, ST_STOP
    } fr_state_e;

    // Number of data bits selected by the length code.
    function automatic logic [CNT_W-1:0] data_bits(input logic [LEN_W-1:0] wl);
        return CNT_W'(MIN_BITS) + CNT_W'(wl);
    endfunction

    // Ones in the low n bit positions.
    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] wl);
        logic [DATA_W:0] t;
        t = ({{DATA_W{1'b0}}, 1'b1} << data_bits(wl)) - 1'b1;
        return t[DATA_W-1:0];
    endfunction

    // High when a right-justified frame (data plus parity) fails the parity check.
    function automatic logic parity_bad(input logic [WIN_W-1:0] fr, input logic pe,
                                        input logic even);
        return pe & ((^fr) == even);
    endfunction
endpackage

// File: rtl/ssrx_sync_det.sv
// Sliding bit window and sync-pattern comparator.
// Shifts every serial bit in at the top, so after L bits a frame sits right below
// the top with its first bit lowest. Exposes the frame before and after the
// current bit and flags a full-frame match with the sync pattern.
module ssrx_sync_det
    import ssrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 ser_in,
    input  logic                 clr,
    input  logic [LEN_W-1:0]     word_len,
    input  logic                 par_en,
    input  logic                 par_even,
    input  logic [DATA_W-1:0]    sync_char,
    output logic [WIN_W-1:0]     frame_nx,
    output logic [WIN_W-1:0]     frame_q,
    output logic                 match
);
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_nx;
    logic [CNT_W-1:0] flen;
    logic [CNT_W-1:0] shamt;
    logic [DATA_W-1:0] sdata;
    logic             spar;
    logic [WIN_W-1:0] pattern;

    // Window register: reloads with idle ones when cleared, shifts on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q <= '1;
        end else if (bit_en) begin
            win_q <= win_nx;
        end
    end

    // Frame extraction and pattern comparison.
    always_comb begin
        win_nx   = {ser_in, win_q[WIN_W-1:1]};
        flen     = data_bits(word_len) + CNT_W'(par_en);
        shamt    = CNT_W'(WIN_W) - flen;
        frame_nx = win_nx >> shamt;
        frame_q  = win_q >> shamt;
        sdata    = sync_char & len_mask(word_len);
        spar     = (^sdata) ^ ~par_even;
        pattern  = {1'b0, sdata};
        if (par_en) begin
            pattern[data_bits(word_len)] = spar;
        end
        match    = bit_en & (frame_nx == pattern);
    end
endmodule

// File: rtl/ssrx_framer.sv
// Frame sequencer: sync hunt and confirmation, character counting and stop check.
// Assumes mode, length and parity settings stay constant while search_en is high.
// Delivers one registered pulse per framed character with its data byte and errors.
module ssrx_framer
    import ssrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 ser_in,
    input  logic [1:0]           mode,
    input  logic                 search_en,
    input  logic                 need_two,
    input  logic [LEN_W-1:0]     word_len,
    input  logic                 par_en,
    input  logic                 par_even,
    input  logic                 match,
    input  logic [WIN_W-1:0]     frame_nx,
    input  logic [WIN_W-1:0]     frame_q,
    output logic                 chr_vld,
    output logic [DATA_W-1:0]    chr_data,
    output logic                 chr_perr,
    output logic                 chr_ferr,
    output logic                 sync_q,
    output logic                 idle
);
    fr_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic             iso;

    // Decode of frame end and start/stop mode.
    always_comb begin
        last = (cnt == data_bits(word_len) + CNT_W'(par_en) - CNT_W'(1));
        iso  = mode[1];
        idle = (st == ST_IDLE);
    end

    // State machine: hunt, confirm, frame, stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sync_q   <= 1'b0;
            chr_vld  <= 1'b0;
            chr_data <= '0;
            chr_perr <= 1'b0;
            chr_ferr <= 1'b0;
        end else begin
            chr_vld <= 1'b0;
            if (!search_en) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                sync_q <= 1'b0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (iso)              st <= ST_START;
                        else if (mode[0])     st <= ST_FRAME;
                        else                  st <= ST_HUNT;
                    end
                    ST_HUNT: begin
                        if (match) begin
                            cnt <= '0;
                            if (need_two) begin
                                st <= ST_CONFIRM;
                            end else begin
                                st     <= ST_FRAME;
                                sync_q <= 1'b1;
                            end
                        end
                    end
                    ST_CONFIRM: begin
                        if (bit_en) begin
                            if (last) begin
                                cnt <= '0;
                                if (match) begin
                                    st     <= ST_FRAME;
                                    sync_q <= 1'b1;
                                end else begin
                                    st <= ST_HUNT;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_FRAME: begin
                        if (bit_en) begin
                            if (last) begin
                                cnt <= '0;
                                if (iso) begin
                                    st <= ST_STOP;
                                end else begin
                                    chr_vld  <= 1'b1;
                                    chr_data <= frame_nx[DATA_W-1:0];
                                    chr_perr <= parity_bad(frame_nx, par_en, par_even);
                                    chr_ferr <= 1'b0;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_START: begin
                        if (bit_en && !ser_in) begin
                            st  <= ST_FRAME;
                            cnt <= '0;
                        end
                    end
                    ST_STOP: begin
                        if (bit_en) begin
                            chr_vld  <= 1'b1;
                            chr_data <= frame_q[DATA_W-1:0];
                            chr_perr <= parity_bad(frame_q, par_en, par_even);
                            chr_ferr <= ~ser_in;
                            st       <= ST_START;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ssrx_hold.sv
// Holding buffer with error flags, done flag and sync stripping.
// Assumes one delivered character per pulse; a stripped character changes nothing.
module ssrx_hold
    import ssrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chr_vld,
    input  logic [DATA_W-1:0]    chr_data,
    input  logic                 chr_perr,
    input  logic                 chr_ferr,
    input  logic [LEN_W-1:0]     word_len,
    input  logic [DATA_W-1:0]    sync_char,
    input  logic                 strip_en,
    input  logic                 rd_strobe,
    output logic                 chr_strip,
    output logic                 done,
    output logic [15:0]          rx_buf
);
    logic [DATA_W-1:0] data_q;
    logic              perr_q;
    logic              ferr_q;
    logic              ovr_q;
    logic [DATA_W-1:0] msk;

    // Strip decision for the character now arriving.
    always_comb begin
        msk       = len_mask(word_len);
        chr_strip = chr_vld & strip_en & ~chr_perr & ~chr_ferr &
                    ((chr_data & msk) == (sync_char & msk));
    end

    // Buffer load, overrun detection and read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
            done   <= 1'b0;
        end else if (chr_vld && !chr_strip) begin
            data_q <= chr_data;
            perr_q <= chr_perr;
            ferr_q <= chr_ferr;
            ovr_q  <= done & ~rd_strobe;
            done   <= 1'b1;
        end else if (rd_strobe) begin
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
            done   <= 1'b0;
        end
    end

    // Program-visible buffer word.
    always_comb begin
        rx_buf = {perr_q | ferr_q | ovr_q, perr_q, ferr_q, ovr_q, 4'b0000, data_q};
    end
endmodule

// File: rtl/ssrx_top.sv
// Synchronous serial receiver top: window/comparator, frame sequencer, holding buffer.
// Assumes bit_en is a single-cycle strobe in the clk domain and settings are static
// while search_en is high.
module ssrx_top
    import ssrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic [1:0]        mode,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              need_two,
    input  logic [DATA_W-1:0] sync_char,
    input  logic              search_en,
    input  logic              strip_en,
    input  logic              rx_ie,
    input  logic              rd_strobe,
    output logic [15:0]       rx_buf,
    output logic              done,
    output logic              irq,
    output logic              in_sync
);
    logic [WIN_W-1:0]  frame_nx;
    logic [WIN_W-1:0]  frame_q;
    logic              match;
    logic              chr_vld;
    logic [DATA_W-1:0] chr_data;
    logic              chr_perr;
    logic              chr_ferr;
    logic              chr_strip;
    logic              sync_q;
    logic              idle;

    ssrx_sync_det i_det (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .clr(idle),
        .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .sync_char(sync_char), .frame_nx(frame_nx), .frame_q(frame_q), .match(match)
    );

    ssrx_framer i_frm (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .mode(mode),
        .search_en(search_en), .need_two(need_two), .word_len(word_len),
        .par_en(par_en), .par_even(par_even), .match(match), .frame_nx(frame_nx),
        .frame_q(frame_q), .chr_vld(chr_vld), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .sync_q(sync_q), .idle(idle)
    );

    ssrx_hold i_hold (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .word_len(word_len),
        .sync_char(sync_char), .strip_en(strip_en), .rd_strobe(rd_strobe),
        .chr_strip(chr_strip), .done(done), .rx_buf(rx_buf)
    );

    // Status outputs: sync indication per mode and gated request.
    always_comb begin
        in_sync = search_en & ((mode == 2'b00) ? sync_q : 1'b1);
        irq     = done & rx_ie;
    end
endmodule

// File: rtl/ssrx_checker.sv
// Temporal checks on the receiver, bound into ssrx_top.
module ssrx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        search_en,
    input logic        rx_ie,
    input logic        rd_strobe,
    input logic [1:0]  mode,
    input logic        chr_vld,
    input logic        chr_strip,
    input logic        done,
    input logic        irq,
    input logic [15:0] rx_buf
);
    // R12: a read with no store in the same cycle clears done and the flags
    a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !(chr_vld && !chr_strip)) |=> (!done && rx_buf[14:12] == 3'b000));

    // R9: a store while done is high and no read is pending flags overrun
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !chr_strip && done && !rd_strobe) |=> rx_buf[12]);

    // R11: a stripped character leaves buffer and done untouched
    a_r11_strip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && chr_strip && !rd_strobe) |=> ($stable(rx_buf) && $stable(done)));

    // R8: characters stored in synchronous modes never carry a framing error
    a_r8_no_frame_err_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !chr_strip && !mode[1]) |=> !rx_buf[13]);

    // R14: no delivery follows a cycle with search off
    a_r14_no_char_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !search_en |=> !chr_vld);

    // R13: no request without the enable
    a_r13_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie |-> !irq);

    // R9: a character stored while done is low carries no overrun
    a_r9_no_false_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !chr_strip && !done) |=> !rx_buf[12]);
endmodule

bind ssrx_top ssrx_checker i_chk (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .rx_ie(rx_ie),
    .rd_strobe(rd_strobe), .mode(mode), .chr_vld(chr_vld), .chr_strip(chr_strip),
    .done(done), .irq(irq), .rx_buf(rx_buf)
);

// File: tb/test_ssrx_top.sv
// Self-checking bench: directed hunt and corner cases mixed with seeded random characters.
module test_ssrx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        ser_in = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  word_len = 2'b11;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        need_two = 1'b1;
    logic [7:0]  sync_char = 8'h16;
    logic        search_en = 1'b0;
    logic        strip_en = 1'b0;
    logic        rx_ie = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [15:0] rx_buf;
    logic        done;
    logic        irq;
    logic        in_sync;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    ssrx_top i_ssrx_top (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .mode(mode),
        .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .need_two(need_two), .sync_char(sync_char), .search_en(search_en),
        .strip_en(strip_en), .rx_ie(rx_ie), .rd_strobe(rd_strobe),
        .rx_buf(rx_buf), .done(done), .irq(irq), .in_sync(in_sync)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int nbits();
        return int'(word_len) + 5;
    endfunction

    function automatic logic [7:0] dmask();
        return 8'((1 << nbits()) - 1);
    endfunction

    // Parity bit that satisfies the programmed sense, optionally inverted.
    function automatic logic good_par(input logic [7:0] d, input logic inj);
        logic p;
        p = ^(d & dmask());
        if (!par_even) p = ~p;
        return p ^ inj;
    endfunction

    // Expected buffer word for a stored character.
    function automatic logic [15:0] exp_buf(input logic [7:0] d, input logic pb,
                                            input logic perr, input logic ferr,
                                            input logic ovr);
        logic [7:0] b;
        b = d & dmask();
        if (par_en && nbits() < 8) b[nbits()] = pb;
        return {perr | ferr | ovr, perr, ferr, ovr, 4'h0, b};
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_bits(input int k);
        for (int i = 0; i < k; i++) send_bit(1'b1);
    endtask

    // Sends one character with current settings; start/stop framing in mode 1x.
    task automatic send_char(input logic [7:0] d, input logic inj, input logic stopb,
                             output logic pb);
        pb = good_par(d, inj);
        if (mode[1]) send_bit(1'b0);
        for (int i = 0; i < nbits(); i++) send_bit(d[i]);
        if (par_en) send_bit(pb);
        if (mode[1]) send_bit(stopb);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_buf();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        search_en = 1'b0;
        repeat (2) @(negedge clk);
        search_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic resync();
        logic pb;
        restart();
        idle_bits(12);
        send_char(sync_char, 1'b0, 1'b1, pb);
        send_char(sync_char, 1'b0, 1'b1, pb);
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic pb;
        logic [7:0] d;
        logic [7:0] d2;
        logic inj;
        logic [15:0] kept;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 buffer after reset", rx_buf, 16'h00FF);
        check("R1 done/irq/in_sync after reset", {13'b0, done, irq, in_sync}, 16'h0000);

        // R4 external and start/stop modes follow search
        mode = 2'b01;
        search_en = 1'b1;
        @(negedge clk);
        check("R4 external in_sync high", {15'b0, in_sync}, 16'h0001);
        mode = 2'b10;
        @(negedge clk);
        check("R4 start/stop in_sync high", {15'b0, in_sync}, 16'h0001);
        search_en = 1'b0;
        @(negedge clk);
        check("R4 in_sync low with search off", {15'b0, in_sync}, 16'h0000);

        // R2 two-match hunt in internal mode, 8 bits, no parity
        mode = 2'b00;
        word_len = 2'b11;
        par_en = 1'b0;
        restart();
        idle_bits(10);
        send_char(sync_char, 1'b0, 1'b1, pb);
        check("R2 one sync frame not enough", {15'b0, in_sync}, 16'h0000);
        send_char(8'hFF, 1'b0, 1'b1, pb);
        check("R2 broken pair no sync", {15'b0, in_sync}, 16'h0000);
        send_char(sync_char, 1'b0, 1'b1, pb);
        send_char(sync_char, 1'b0, 1'b1, pb);
        check("R2 sync pair declares sync", {15'b0, in_sync}, 16'h0001);
        check("R2 hunt frames not delivered", {15'b0, done}, 16'h0000);

        // R5 R13 R12 random 8-bit characters
        for (int k = 0; k < 12; k++) begin
            d = 8'($urandom);
            send_char(d, 1'b0, 1'b1, pb);
            check("R5 8-bit character", rx_buf, exp_buf(d, pb, 1'b0, 1'b0, 1'b0));
            check("R13 irq with done and enable", {14'b0, done, irq}, 16'h0003);
            read_buf();
            check("R12 read clears done", {14'b0, done, irq}, 16'h0000);
        end

        // R5 R6 R7 R10 all lengths, parity on/off, random sense and injected errors
        for (int wl = 0; wl < 4; wl++) begin
            for (int pe = 0; pe < 2; pe++) begin
                word_len = 2'(wl);
                par_en = 1'(pe);
                par_even = 1'($urandom);
                resync();
                check("R2 resync at new length", {15'b0, in_sync}, 16'h0001);
                for (int k = 0; k < 6; k++) begin
                    d = 8'($urandom);
                    inj = (($urandom % 4) == 0) ? 1'b1 : 1'b0;
                    send_char(d, inj & par_en, 1'b1, pb);
                    check("R6 R7 R10 character with parity", rx_buf,
                          exp_buf(d, pb, inj & par_en, 1'b0, 1'b0));
                    read_buf();
                end
            end
        end

        // R9 R10 overrun, then R12 read keeps data
        word_len = 2'b10;
        par_en = 1'b0;
        resync();
        d = 8'h2B;
        d2 = 8'h54;
        send_char(d, 1'b0, 1'b1, pb);
        send_char(d2, 1'b0, 1'b1, pb);
        check("R9 overrun flag and new data", rx_buf, exp_buf(d2, pb, 1'b0, 1'b0, 1'b1));
        read_buf();
        check("R12 read keeps data clears flags", rx_buf, {8'h00, d2 & 8'h7F});

        // R13 enable low masks request
        rx_ie = 1'b0;
        send_char(8'h11, 1'b0, 1'b1, pb);
        check("R13 irq low when disabled", {14'b0, done, irq}, 16'h0002);
        read_buf();
        rx_ie = 1'b1;

        // R11 sync stripping, 8 bits with even parity
        word_len = 2'b11;
        par_en = 1'b1;
        par_even = 1'b1;
        resync();
        strip_en = 1'b1;
        send_char(8'hA5, 1'b0, 1'b1, pb);
        read_buf();
        kept = rx_buf;
        check("R11 setup character", kept, 16'h00A5);
        send_char(sync_char, 1'b0, 1'b1, pb);
        check("R11 clean sync stripped: done", {15'b0, done}, 16'h0000);
        check("R11 clean sync stripped: buffer", rx_buf, kept);
        send_char(sync_char, 1'b1, 1'b1, pb);
        check("R11 sync with parity error kept", rx_buf,
              exp_buf(sync_char, pb, 1'b1, 1'b0, 1'b0));
        check("R11 sync with error sets done", {15'b0, done}, 16'h0001);
        read_buf();
        strip_en = 1'b0;

        // R8 start/stop framing, 6 bits odd parity
        mode = 2'b10;
        word_len = 2'b01;
        par_en = 1'b1;
        par_even = 1'b0;
        restart();
        idle_bits(3);
        check("R4 start/stop in_sync", {15'b0, in_sync}, 16'h0001);
        for (int k = 0; k < 4; k++) begin
            d = 8'($urandom);
            send_char(d, 1'b0, 1'b1, pb);
            check("R8 good stop bit", rx_buf, exp_buf(d, pb, 1'b0, 1'b0, 1'b0));
            read_buf();
            idle_bits(1);
        end
        d = 8'h1C;
        send_char(d, 1'b0, 1'b0, pb);
        check("R8 bad stop bit flags framing", rx_buf, exp_buf(d, pb, 1'b0, 1'b1, 1'b0));
        read_buf();
        idle_bits(2);

        // R14 search off: traffic ignored
        mode = 2'b00;
        word_len = 2'b11;
        par_en = 1'b0;
        @(negedge clk);
        search_en = 1'b0;
        kept = rx_buf;
        for (int i = 0; i < 20; i++) send_bit(1'($urandom));
        repeat (3) @(negedge clk);
        check("R14 no delivery with search off", {15'b0, done}, 16'h0000);
        check("R14 buffer unchanged with search off", rx_buf, kept);
        check("R14 in_sync low with search off", {15'b0, in_sync}, 16'h0000);

        // R3 single-match sync
        need_two = 1'b0;
        restart();
        idle_bits(10);
        send_char(sync_char, 1'b0, 1'b1, pb);
        check("R3 single sync frame declares sync", {15'b0, in_sync}, 16'h0001);
        send_char(8'h3C, 1'b0, 1'b1, pb);
        check("R3 first character after single sync", rx_buf, 16'h003C);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule